// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block steers operand sources and interlocks for a five-stage in-order pipeline: fetch, decode with register read, execute, memory access and write-back. Every clock the datapath hands it the two source register numbers of the instruction sitting in decode, plus the destination number, write flag and load flag of the older instructions held in the execute latch, the execute-to-memory latch and the memory-to-write-back latch. The block returns the operand selects that the execute stage multiplexers use, the hold controls for fetch and decode, and the bubble control for the execute latch.

The bypass choice for each operand is worked out while the instruction is still in decode and is registered as it moves into execute. Before that move the instruction in the execute latch and the one in the memory latch are the ones that will sit one and two places ahead of it. A dependent instruction right behind an ALU instruction therefore takes the result straight from the execute-to-memory latch with no lost cycle. A dependent instruction right behind a load has to wait: the load's data exists only after the memory stage. So the controller holds fetch and decode for one cycle and sends a no-op into execute. On the following cycle it routes the loaded value from the memory-to-write-back latch. A register written back in the same cycle that decode reads it is flagged so the register read returns the new value.

Top module: `hz_ctrl`

## Requirements
- R1: While `rst` is high, each rising clock edge sets `fwd_a` and `fwd_b` to 2'b00 (register file).
- R2: If a decode source equals `ex_rd`, `ex_we` is 1 and `ex_is_load` is 0, then after the next rising edge that operand's select is 2'b01 (execute-to-memory latch), and no hold or bubble is raised.
- R3: If a decode source matches only `mem_rd` with `mem_we` 1, then after the next edge that operand's select is 2'b10 (memory-to-write-back latch).
- R4: When a source matches both `ex_rd` (with `ex_we`) and `mem_rd` (with `mem_we`), the younger producer wins and the select becomes 2'b01.
- R5: A producer whose write flag is 0 never causes forwarding or a hold, even when its register number matches, and even when it is a load.
- R6: `stall_fetch`, `stall_decode` and `bubble_ex` are high in the same cycle exactly when `ex_we` and `ex_is_load` are 1 and `ex_rd` equals `id_rs1` or `id_rs2`. A load whose destination matches neither source causes no hold.
- R7: At the edge that ends a load-use hold cycle, both selects become 2'b00 for the injected no-op.
- R8: In the cycle after a load-use hold, the load now sits in the memory latch (`mem_rd`, `mem_we`), and after the next edge the waiting operand's select is 2'b10.
- R9: The two operands are resolved independently: each select depends only on its own source number.
- R10: `wbyp_a` (`wbyp_b`) is high in the same cycle when `wb_we` is 1 and `wb_rd` equals `id_rs1` (`id_rs2`).
- R11: Register 0 is an ordinary register: a write to it is forwarded, bypassed and interlocked like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 4 | First source register of the instruction in decode |
| id_rs2 | input | 4 | Second source register of the instruction in decode |
| ex_rd | input | 4 | Destination of the instruction in the execute latch |
| ex_we | input | 1 | Execute-latch instruction writes a register |
| ex_is_load | input | 1 | Execute-latch instruction is a load |
| mem_rd | input | 4 | Destination held in the execute-to-memory latch |
| mem_we | input | 1 | Write flag of the execute-to-memory latch |
| wb_rd | input | 4 | Destination held in the memory-to-write-back latch |
| wb_we | input | 1 | Write flag of the memory-to-write-back latch |
| fwd_a | output | 2 | First operand select in execute: 00 file, 01 EX/MEM, 10 MEM/WB |
| fwd_b | output | 2 | Second operand select in execute, same encoding |
| wbyp_a | output | 1 | Decode read of first source takes the write-back value |
| wbyp_b | output | 1 | Decode read of second source takes the write-back value |
| stall_fetch | output | 1 | Hold the program counter |
| stall_decode | output | 1 | Hold the fetch-to-decode latch |
| bubble_ex | output | 1 | Load a no-op into the execute latch |

## Verification
Every cycle the assertions check these points. A load hazard raises all three hold controls together. A bubble is followed by register-file selects. An execute-latch match wins over a memory-latch match. The code 2'b11 never appears on a select. A write-back match raises the decode bypass. Only the bench's scenarios show the complete load-use sequence: one held cycle, then the loaded value routed from the memory-to-write-back latch. The same holds for reset clearing selects that were non-zero, and for register 0 being handled like any other register.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } src_sel_e;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hz_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic [RW-1:0] rs,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  output src_sel_e      nxt_sel,
  output logic          ex_hit,
  output logic          wb_hit
);
  logic mem_hit;

  assign ex_hit  = ex_we  && (ex_rd  == rs);
  assign mem_hit = mem_we && (mem_rd == rs);
  assign wb_hit  = wb_we  && (wb_rd  == rs);

  // younger producer (execute latch) takes priority
  always_comb begin
    if (ex_hit)       nxt_sel = SRC_EXMEM;
    else if (mem_hit) nxt_sel = SRC_MEMWB;
    else              nxt_sel = SRC_RF;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
(
  input  logic [NSRC-1:0] ex_hit,
  input  logic            ex_is_load,
  output logic            hold
);
  assign hold = ex_is_load && (|ex_hit);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          wbyp_a,
  output logic          wbyp_b,
  output logic          stall_fetch,
  output logic          stall_decode,
  output logic          bubble_ex
);
  logic [RW-1:0]   rs      [NSRC];
  src_sel_e        nxt_sel [NSRC];
  src_sel_e        sel_q   [NSRC];
  logic [NSRC-1:0] ex_hit;
  logic [NSRC-1:0] wb_hit;
  logic            hold;

  assign rs[0] = id_rs1;
  assign rs[1] = id_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    hz_operand_fwd #(.RW(RW)) u_op (
      .rs      (rs[g]),
      .ex_rd   (ex_rd),
      .ex_we   (ex_we),
      .mem_rd  (mem_rd),
      .mem_we  (mem_we),
      .wb_rd   (wb_rd),
      .wb_we   (wb_we),
      .nxt_sel (nxt_sel[g]),
      .ex_hit  (ex_hit[g]),
      .wb_hit  (wb_hit[g])
    );
  end

  hz_loaduse u_lu (
    .ex_hit     (ex_hit),
    .ex_is_load (ex_is_load),
    .hold       (hold)
  );

  // selects travel with the instruction into the execute latch
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (rst || hold) sel_q[i] <= SRC_RF;
      else             sel_q[i] <= nxt_sel[i];
    end
  end

  assign fwd_a        = sel_q[0];
  assign fwd_b        = sel_q[1];
  assign wbyp_a       = wb_hit[0];
  assign wbyp_b       = wb_hit[1];
  assign stall_fetch  = hold;
  assign stall_decode = hold;
  assign bubble_ex    = hold;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic [RW-1:0] ex_rd,
  input logic          ex_we,
  input logic          ex_is_load,
  input logic [RW-1:0] mem_rd,
  input logic          mem_we,
  input logic [RW-1:0] wb_rd,
  input logic          wb_we,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          wbyp_a,
  input logic          wbyp_b,
  input logic          stall_fetch,
  input logic          stall_decode,
  input logic          bubble_ex
);
  p_ld_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ex_we && ex_is_load && (ex_rd == id_rs1 || ex_rd == id_rs2))
      |-> (stall_fetch && stall_decode && bubble_ex));

  p_hold_agree_r6: assert property (@(posedge clk) disable iff (rst)
    (stall_fetch == bubble_ex) && (stall_decode == bubble_ex));

  p_nonload_nohold_r2: assert property (@(posedge clk) disable iff (rst)
    !(ex_we && ex_is_load) |-> !bubble_ex);

  p_bubble_rf_r7: assert property (@(posedge clk) disable iff (rst)
    bubble_ex |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  p_ex_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (!bubble_ex && ex_we && ex_rd == id_rs1 && mem_we && mem_rd == id_rs1)
      |=> (fwd_a == 2'b01));

  p_mem_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (!bubble_ex && !(ex_we && ex_rd == id_rs2) && mem_we && mem_rd == id_rs2)
      |=> (fwd_b == 2'b10));

  p_no_code3_r9: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  p_wb_bypass_r10: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_rd == id_rs1) |-> wbyp_a);

  p_wb_bypass_b_r10: assert property (@(posedge clk) disable iff (rst)
    !wb_we |-> (!wbyp_a && !wbyp_b));
endmodule

bind hz_ctrl hz_ctrl_chk #(.RW(RW)) u_chk (.*);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
  localparam int NREG = 16;
  localparam int RW   = $clog2(NREG);
  localparam int VW   = 31;
  localparam int NV   = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic          ex_we = 1'b0, ex_is_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
  logic [1:0]    fwd_a, fwd_b;
  logic          wbyp_a, wbyp_b, stall_fetch, stall_decode, bubble_ex;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hz_ctrl #(.NREG(NREG)) dut (.*);

  // fields: rs1 rs2 exrd exwe exld memrd memwe wbrd wbwe | hold wa wb fa fb
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1, 4'd2,  4'd1,  1'b0,1'b0, 4'd2,  1'b0, 4'd1,  1'b0, 1'b0,1'b0,1'b0, 2'b00,2'b00}, // R5
    {4'd3, 4'd4,  4'd3,  1'b1,1'b0, 4'd9,  1'b1, 4'd9,  1'b0, 1'b0,1'b0,1'b0, 2'b01,2'b00}, // R2
    {4'd5, 4'd6,  4'd9,  1'b1,1'b0, 4'd6,  1'b1, 4'd9,  1'b0, 1'b0,1'b0,1'b0, 2'b00,2'b10}, // R3
    {4'd7, 4'd7,  4'd7,  1'b1,1'b0, 4'd7,  1'b1, 4'd7,  1'b1, 1'b0,1'b1,1'b1, 2'b01,2'b01}, // R4
    {4'd8, 4'd2,  4'd8,  1'b1,1'b1, 4'd2,  1'b1, 4'd0,  1'b0, 1'b1,1'b0,1'b0, 2'b00,2'b00}, // R6 R7
    {4'd8, 4'd2,  4'd5,  1'b1,1'b1, 4'd2,  1'b1, 4'd0,  1'b0, 1'b0,1'b0,1'b0, 2'b00,2'b10}, // R6 no match
    {4'd0, 4'd0,  4'd0,  1'b1,1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0,1'b0,1'b0, 2'b01,2'b01}, // R11
    {4'd12,4'd13, 4'd1,  1'b0,1'b0, 4'd2,  1'b0, 4'd13, 1'b1, 1'b0,1'b0,1'b1, 2'b00,2'b00}, // R10
    {4'd14,4'd15, 4'd14, 1'b1,1'b0, 4'd15, 1'b1, 4'd3,  1'b0, 1'b0,1'b0,1'b0, 2'b01,2'b10}, // R9
    {4'd4, 4'd4,  4'd4,  1'b0,1'b1, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0,1'b0,1'b0, 2'b00,2'b00}, // R5 load
    {4'd1, 4'd10, 4'd10, 1'b1,1'b1, 4'd1,  1'b1, 4'd0,  1'b0, 1'b1,1'b0,1'b0, 2'b00,2'b00}  // R6 src2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [VW-1:0] v);
    {id_rs1, id_rs2, ex_rd, ex_we, ex_is_load, mem_rd, mem_we, wb_rd, wb_we} = v[VW-1:7];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset clears selects while inputs would request forwarding
    @(negedge clk);
    id_rs1 = 4'd3; id_rs2 = 4'd3; ex_rd = 4'd3; ex_we = 1'b1;
    @(posedge clk); #2;
    check(fwd_a == 2'b00, "R1 fwd_a", fwd_a, 0);
    check(fwd_b == 2'b00, "R1 fwd_b", fwd_b, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check(fwd_a == 2'b01, "R2 after reset fwd_a", fwd_a, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check(fwd_a == 2'b00, "R1 reset clears fwd_a", fwd_a, 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(VEC[i]);
      #2;
      check(stall_fetch  == VEC[i][6], $sformatf("R6 stall_fetch v%0d", i), stall_fetch, VEC[i][6]);
      check(stall_decode == VEC[i][6], $sformatf("R6 stall_decode v%0d", i), stall_decode, VEC[i][6]);
      check(bubble_ex    == VEC[i][6], $sformatf("R6 bubble_ex v%0d", i), bubble_ex, VEC[i][6]);
      check(wbyp_a == VEC[i][5], $sformatf("R10 wbyp_a v%0d", i), wbyp_a, VEC[i][5]);
      check(wbyp_b == VEC[i][4], $sformatf("R10 wbyp_b v%0d", i), wbyp_b, VEC[i][4]);
      @(posedge clk); #2;
      check(fwd_a == VEC[i][3:2], $sformatf("R9 fwd_a v%0d", i), fwd_a, VEC[i][3:2]);
      check(fwd_b == VEC[i][1:0], $sformatf("R9 fwd_b v%0d", i), fwd_b, VEC[i][1:0]);
    end

    // R8: full load-use sequence on source 2
    @(negedge clk);
    id_rs1 = 4'd9; id_rs2 = 4'd5; ex_rd = 4'd5; ex_we = 1'b1; ex_is_load = 1'b1;
    mem_rd = 4'd0; mem_we = 1'b0; wb_rd = 4'd0; wb_we = 1'b0;
    #2;
    check(stall_decode == 1'b1, "R6 load-use hold", stall_decode, 1);
    @(posedge clk); #2;
    check(fwd_b == 2'b00, "R7 bubble selects", fwd_b, 0);
    @(negedge clk);
    ex_we = 1'b0; ex_is_load = 1'b0; ex_rd = 4'd0;
    mem_rd = 4'd5; mem_we = 1'b1;
    #2;
    check(stall_fetch == 1'b0, "R8 hold released", stall_fetch, 0);
    @(posedge clk); #2;
    check(fwd_b == 2'b10, "R8 loaded value from MEM/WB", fwd_b, 2);
    check(fwd_a == 2'b00, "R9 other operand untouched", fwd_a, 0);

    // R11: load into register 0 interlocks like any other
    @(negedge clk);
    id_rs1 = 4'd0; id_rs2 = 4'd6; ex_rd = 4'd0; ex_we = 1'b1; ex_is_load = 1'b1;
    mem_we = 1'b0; wb_rd = 4'd0; wb_we = 1'b1;
    #2;
    check(bubble_ex == 1'b1, "R11 r0 load-use", bubble_ex, 1);
    check(wbyp_a == 1'b1, "R11 r0 write-back bypass", wbyp_a, 1);
    @(posedge clk); #2;
    finish_run();
  end
endmodule